// File: doc/BRIEF.md
# Tick-Driven Watchdog Reset Timer

This block guards a system against runaway software. It counts pulses from an external periodic tick source and, when eight ticks accumulate without being serviced, asks the rest of the chip for a reset. Software keeps the system alive by writing a value with bit 0 cleared to one fixed clear address on a simple write port. A clear empties only the watchdog's own counter. The upstream tick divider keeps running, so the real time to a timeout after a clear lies between seven and eight tick periods.

A level input marks the high-voltage programming mode. While it is high, a timeout does not produce a reset request, but the counter still wraps. Each reset request is a fixed-length pulse, and a sticky cause flag records that the watchdog fired. The flag clears only on the block's own power-on reset. The counter is active from reset and has no disable. Because it runs from the system clock, it cannot detect a stopped clock.

Top module: `tick_watchdog`

## Requirements
- R1: Each cycle with `tick_i` high and no clear write advances the watchdog count by one. Cycles without a tick leave the count unchanged, however many idle cycles separate the ticks.
- R2: On the clock edge that samples the eighth tick since reset, a clear, or the previous wrap, `wdt_rst_o` goes high, provided `prog_mode_i` is low in that cycle.
- R3: A write with `wr_en_i` high, `wr_addr_i` equal to 16'h07F0 and `wr_data_i[0]` equal to 0 returns the count to zero. A full eight further ticks are then needed for a timeout.
- R4: A write to 16'h07F0 with `wr_data_i[0]` equal to 1 leaves the count unchanged. A write to any other address also leaves the count unchanged.
- R5: When a clear write and a tick occur in the same cycle, the clear wins, and the count afterwards is zero.
- R6: A timeout in a cycle with `prog_mode_i` high raises neither `wdt_rst_o` nor `wdt_cause_o`. The count still wraps to zero, and eight more ticks are needed for the next timeout.
- R7: `wdt_rst_o` stays high for exactly 4 clock cycles per timeout and then returns low. The count is zero after the timeout.
- R8: `wdt_cause_o` is set together with the reset pulse. It then stays high until `rst_n` is asserted.
- R9: While `rst_n` is low, `wdt_rst_o` and `wdt_cause_o` are low and the count is zero. Asserting `rst_n` takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that drives the counter |
| rst_n | input | 1 | Active-low asynchronous power-on reset; its release is synchronous to clk |
| tick_i | input | 1 | Single-cycle pulse from the periodic tick divider |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 16 | Bus write address |
| wr_data_i | input | 8 | Bus write data; only bit 0 is decoded |
| prog_mode_i | input | 1 | High while the programming-voltage pin is outside the normal logic range |
| wdt_rst_o | output | 1 | Reset request pulse, 4 cycles long |
| wdt_cause_o | output | 1 | Sticky flag recording that a watchdog reset was requested |

## Verification
The assertions assume that `tick_i` is a one-cycle pulse synchronous to `clk`. They also assume that no second timeout can arrive while a reset pulse is still running. Eight ticks are needed per timeout and the pulse lasts only four cycles, so this holds whenever ticks are at most one per cycle. The stimulus drives every input at the falling edge and holds it for one full cycle. It never raises the tick for more than one cycle at a time, and it idles between actions, so the pulse-length checks see only isolated pulses.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Reset pulse generator states
  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_HOLD = 1'b1
  } pulse_state_e;

  // Width needed to hold values 0..n-1, never below one bit
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wdt_clear_decode.sv
module wdt_clear_decode #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] CLR_ADDR = 16'h07F0
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              clear_o
);

  logic addr_hit;
  logic data_unused;

  // Only bit 0 of the data carries meaning
  assign data_unused = ^wr_data_i[DATA_W-1:1];
  assign addr_hit    = (wr_addr_i == ADDR_W'(CLR_ADDR));
  assign clear_o     = wr_en_i & addr_hit & ~wr_data_i[0];

endmodule

// File: rtl/wdt_stage_chain.sv
module wdt_stage_chain #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              clear_i,
  output logic [STAGES-1:0] count_o,
  output logic              carry_o
);

  localparam int CW = STAGES;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;
  logic [STAGES:0]   carry;

  // Ripple enable through toggle stages; the clear has priority over the tick
  assign carry[0] = tick_i & ~clear_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign carry[i+1] = carry[i] & stage_q[i];
    always_comb begin
      if (clear_i) stage_d[i] = 1'b0;
      else         stage_d[i] = stage_q[i] ^ carry[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign count_o = stage_q;
  assign carry_o = carry[STAGES];

  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clear_i) |=> (count_o == CW'($past(count_o) + 1'b1)));

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clear_i) |=> $stable(count_o));

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == '0));

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && tick_i) |=> (count_o == '0));

endmodule

// File: rtl/wdt_reset_pulse.sv
module wdt_reset_pulse
  import wdt_pkg::*;
#(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic rst_o
);

  localparam int CNT_W = cnt_width(PULSE_CYC);

  pulse_state_e     state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    unique case (state_q)
      PS_IDLE: begin
        if (fire_i) begin
          state_d  = PS_HOLD;
          remain_d = CNT_W'(PULSE_CYC - 1);
        end
      end
      PS_HOLD: begin
        if (fire_i) begin
          remain_d = CNT_W'(PULSE_CYC - 1);
        end else if (remain_q == '0) begin
          state_d = PS_IDLE;
        end else begin
          remain_d = remain_q - 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_IDLE;
      remain_q <= '0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
    end
  end

  assign rst_o = (state_q == PS_HOLD);

  // Checker: length of the current high run of rst_o
  logic [CNT_W:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_run_q <= '0;
    else if (rst_o) hi_run_q <= hi_run_q + 1'b1;
    else            hi_run_q <= '0;
  end

  p_pulse_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> rst_o);

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> ($past(hi_run_q) == (CNT_W+1)'(PULSE_CYC - 1)));

  p_pulse_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> (hi_run_q < (CNT_W+1)'(PULSE_CYC)));

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] CLR_ADDR  = 16'h07F0,
  parameter int          STAGES    = 3,
  parameter int          PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              prog_mode_i,
  output logic              wdt_rst_o,
  output logic              wdt_cause_o
);

  logic              clear;
  logic              carry;
  logic              fire;
  logic [STAGES-1:0] count;
  logic              cause_q, cause_d;

  wdt_clear_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CLR_ADDR(CLR_ADDR)
  ) i_decode (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .clear_o  (clear)
  );

  wdt_stage_chain #(
    .STAGES(STAGES)
  ) i_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .clear_i(clear),
    .count_o(count),
    .carry_o(carry)
  );

  // Timeout leads to a reset request only outside programming mode
  assign fire = carry & ~prog_mode_i;

  wdt_reset_pulse #(
    .PULSE_CYC(PULSE_CYC)
  ) i_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire_i(fire),
    .rst_o (wdt_rst_o)
  );

  always_comb begin
    cause_d = cause_q;
    if (fire) cause_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= 1'b0;
    else        cause_q <= cause_d;
  end

  assign wdt_cause_o = cause_q;

  p_prog_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> !$past(prog_mode_i));

  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> (count == '0));

  p_cause_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_cause_o |=> wdt_cause_o);

  p_cause_with_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> wdt_cause_o);

  p_reset_state_r9: assert property (@(posedge clk)
    !rst_n |-> (!wdt_rst_o && !wdt_cause_o && (count == '0)));

endmodule

// File: tb/test_tick_watchdog.sv
module test_tick_watchdog;

  localparam logic [2:0] A_IDLE  = 3'd0;
  localparam logic [2:0] A_TICK  = 3'd1;
  localparam logic [2:0] A_CLR   = 3'd2;
  localparam logic [2:0] A_BDATA = 3'd3;
  localparam logic [2:0] A_BADDR = 3'd4;
  localparam logic [2:0] A_TCLR  = 3'd5;

  typedef struct packed {
    logic [2:0] act;
    logic [3:0] reps;
    logic       prog;
    logic       exp_rst;
    logic       exp_cause;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{A_TICK,  4'd7, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 seven ticks, no timeout yet
    '{A_CLR,   4'd1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 clear write
    '{A_TICK,  4'd7, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 restart needs eight again
    '{A_BDATA, 4'd1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 bit0=1 ignored
    '{A_BADDR, 4'd1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 other address ignored
    '{A_TICK,  4'd1, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 eighth tick fires
    '{A_IDLE,  4'd3, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 pulse still high
    '{A_IDLE,  4'd1, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 pulse over, R8 flag kept
    '{A_TICK,  4'd7, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 count restarted at zero
    '{A_TCLR,  4'd1, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 clear beats tick
    '{A_TICK,  4'd7, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 tick was not counted
    '{A_TICK,  4'd1, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 timeout blocked
    '{A_TICK,  4'd7, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 count wrapped
    '{A_TICK,  4'd1, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 next timeout fires
    '{A_IDLE,  4'd4, 1'b0, 1'b0, 1'b1, 4'd7}   // R7 four-cycle pulse
  };

  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        wr_en_i;
  logic [15:0] wr_addr_i;
  logic [7:0]  wr_data_i;
  logic        prog_mode_i;
  logic        wdt_rst_o;
  logic        wdt_cause_o;

  int checks;
  int failures;
  int hi_cnt;

  tick_watchdog i_tick_watchdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .prog_mode_i(prog_mode_i),
    .wdt_rst_o  (wdt_rst_o),
    .wdt_cause_o(wdt_cause_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  // Drive one action for one full cycle, return after the next falling edge
  task automatic do_act(input logic [2:0] act, input logic prog);
    tick_i      = (act == A_TICK) || (act == A_TCLR);
    wr_en_i     = (act == A_CLR) || (act == A_BDATA) || (act == A_BADDR) || (act == A_TCLR);
    wr_addr_i   = (act == A_BADDR) ? 16'h07F1 : 16'h07F0;
    wr_data_i   = (act == A_BDATA) ? 8'h01 : 8'hFE;
    prog_mode_i = prog;
    @(posedge clk);
    @(negedge clk);
    tick_i      = 1'b0;
    wr_en_i     = 1'b0;
    prog_mode_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0;
    wr_addr_i = '0; wr_data_i = '0; prog_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 rst in reset", wdt_rst_o, 1'b0);
    check("R9 cause in reset", wdt_cause_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 rst after release", wdt_rst_o, 1'b0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VEC[v].reps); k++) do_act(VEC[v].act, VEC[v].prog);
      checks++;
      if (wdt_rst_o !== VEC[v].exp_rst || wdt_cause_o !== VEC[v].exp_cause) begin
        failures++;
        $display("FAIL R%0d vec %0d got rst=%b cause=%b exp rst=%b cause=%b",
                 VEC[v].req, v, wdt_rst_o, wdt_cause_o, VEC[v].exp_rst, VEC[v].exp_cause);
      end
    end

    // R9 asynchronous reset clears the sticky flag (R8)
    #1 rst_n = 1'b0;
    #1 check("R8 cause cleared by rst_n", wdt_cause_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 fresh timeout in programming mode leaves cause low
    for (int k = 0; k < 7; k++) do_act(A_TICK, 1'b0);
    do_act(A_TICK, 1'b1);
    check("R6 no rst in prog mode", wdt_rst_o, 1'b0);
    for (int k = 0; k < 4; k++) begin
      do_act(A_IDLE, 1'b0);
      check("R6 no rst later", wdt_rst_o, 1'b0);
    end
    check("R6 cause stays low", wdt_cause_o, 1'b0);

    // R1 ticks separated by idle gaps still count
    for (int k = 0; k < 7; k++) begin
      do_act(A_TICK, 1'b0);
      do_act(A_IDLE, 1'b0);
      do_act(A_IDLE, 1'b0);
    end
    check("R1 no early timeout with gaps", wdt_rst_o, 1'b0);
    do_act(A_TICK, 1'b0);
    check("R2 timeout on eighth gapped tick", wdt_rst_o, 1'b1);
    check("R8 cause set with pulse", wdt_cause_o, 1'b1);

    // R7 measure pulse width
    hi_cnt = 1;
    for (int k = 0; k < 8; k++) begin
      do_act(A_IDLE, 1'b0);
      if (wdt_rst_o) hi_cnt++;
    end
    checks++;
    if (hi_cnt != 4) begin
      failures++;
      $display("FAIL R7 pulse width got=%0d exp=4", hi_cnt);
    end

    // R9 reset during an active pulse
    for (int k = 0; k < 8; k++) do_act(A_TICK, 1'b0);
    check("R2 second timeout", wdt_rst_o, 1'b1);
    #1 rst_n = 1'b0;
    #1 check("R9 pulse cut by rst_n", wdt_rst_o, 1'b0);
    check("R9 cause cut by rst_n", wdt_cause_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 7; k++) do_act(A_TICK, 1'b0);
    check("R9 count zero after reset", wdt_rst_o, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule